// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Arbiter

The arbiter looks at four interrupt sources every clock: two timer overflow flags, a serial port that has two event flags, and a second-timer flag. It also reads a shared enable register and a priority register. From these it picks at most one source to service. When it accepts a source it raises a one-cycle acceptance pulse. The pulse carries the 16-bit vector address and the level taken. On the same cycle it issues a hardware clear pulse for whichever timer overflow flag it just accepted. The serial and second-timer flags are left alone for software to clear.

The arbiter keeps track of the priority level that is currently active. The encoding is: none, low, high. A new request is only accepted when its level is strictly above the active level. Accepting a request pushes the previous level onto a small stack. A return strobe from the core pops the stack and restores that earlier level.

The acceptance output is a plain pulse with no ready input. The consumer must act on it in the cycle it appears, so the arbiter never applies back-pressure. Raising the active level is what stops the same request from being accepted again. That protection holds until the return strobe.

Top module: `irq_two_level_arbiter`

## Requirements
- R1: No request is accepted while bit 7 of `en_reg` (global enable) is 0.
- R2: A source can be accepted only when its own enable bit in `en_reg` is 1. The bits are: bit 1 for timer 0, bit 3 for timer 1, bit 4 for serial, bit 5 for timer 2.
- R3: A source is high level when its bit in `prio_reg` is 1 and low level otherwise, using the same bit positions as R2. Any pending high-level source is chosen before every low-level source.
- R4: Within one level the fixed order is timer 0, then timer 1, then serial, then timer 2. The first pending and enabled source in that order wins.
- R5: Pending conditions and vectors are:
  - timer 0: `tmr_ctl[5]`, vector 0x000B
  - timer 1: `tmr_ctl[7]`, vector 0x001B
  - serial: `ser_ctl[0]` or `ser_ctl[1]`, vector 0x0023
  - timer 2: `t2_ctl[7]`, vector 0x002B
- R6: Accepting timer 0 pulses `clr_t0_ovf`, and accepting timer 1 pulses `clr_t1_ovf`. Each pulse lasts one cycle and coincides with `take_valid`. Accepting serial or timer 2 never pulses either clear.
- R7: `active_lvl` is 0 after reset (0 = none, 1 = low, 2 = high). A request is accepted only if its level is strictly above `active_lvl`. A pending request at an equal or lower level is held off.
- R8: An acceptance sets `active_lvl` to the level taken. Each `ret_strobe` cycle restores the level that was active before the most recent acceptance still outstanding. A strobe with nothing outstanding leaves `active_lvl` at 0.
- R9: Inputs sampled at clock edge k produce the acceptance on the outputs after edge k. `take_valid` is high for that one cycle, with `take_vector` and `take_high` (1 = high level) valid alongside it.
- R10: No request is accepted in a cycle where `ret_strobe` is high. Only the return takes effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_reg | input | 8 | Enable register: bit 7 global, bits 1/3/4/5 per source |
| prio_reg | input | 8 | Priority register: bits 1/3/4/5 select high level |
| tmr_ctl | input | 8 | Timer control flags: bit 5 timer 0 overflow, bit 7 timer 1 overflow |
| ser_ctl | input | 8 | Serial control flags: bits 1:0 events |
| t2_ctl | input | 8 | Timer 2 control flags: bit 7 event |
| ret_strobe | input | 1 | One-cycle return-from-service strobe |
| take_valid | output | 1 | One-cycle acceptance pulse |
| take_vector | output | 16 | Vector address of the accepted source |
| take_high | output | 1 | Level of the accepted source, 1 = high |
| clr_t0_ovf | output | 1 | Clear pulse for the timer 0 overflow flag |
| clr_t1_ovf | output | 1 | Clear pulse for the timer 1 overflow flag |
| active_lvl | output | 2 | Active priority level: 0 none, 1 low, 2 high |

## Verification
The embedded properties assume that every flag and register input is synchronous to `clk`. They also assume that `ret_strobe` pairs with an earlier acceptance. An unmatched strobe is tolerated, but the property on stack room relies on the strict-raise rule, which limits nesting to two levels. The stimulus changes inputs only on the falling edge. It clears a timer flag in the cycle after its clear pulse, the way the owning timer would. It removes serial and timer 2 flags itself before each return, the way software would. Every return it issues has a matching acceptance, except one deliberate strobe issued with nothing outstanding.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int SRC_COUNT     = 4;
  localparam int LEVEL_COUNT   = 2;
  localparam int GLOBAL_EN_BIT = 7;
  localparam int REG_W         = 8;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2
  } lvl_e;

  // Bit position of a source in the enable and priority registers.
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

  // Vectors sit eight bytes apart, starting at 3, indexed by the enable bit.
  function automatic int src_vector(input int idx);
    return 3 + 8 * src_bit(idx);
  endfunction

endpackage

// File: rtl/irq_source_decode.sv
module irq_source_decode
  import irq_pkg::*;
(
  input  logic [REG_W-1:0]     en_reg,
  input  logic [REG_W-1:0]     prio_reg,
  input  logic [REG_W-1:0]     tmr_ctl,
  input  logic [REG_W-1:0]     ser_ctl,
  input  logic [REG_W-1:0]     t2_ctl,
  output logic [SRC_COUNT-1:0] req_high,
  output logic [SRC_COUNT-1:0] req_low
);

  logic [SRC_COUNT-1:0] pend;
  logic                 glob_on;

  assign glob_on = en_reg[GLOBAL_EN_BIT];

  // Per-source pending flags, in scan order.
  always_comb begin
    pend    = '0;
    pend[0] = tmr_ctl[5];
    pend[1] = tmr_ctl[7];
    pend[2] = |ser_ctl[1:0];
    pend[3] = t2_ctl[7];
  end

  for (genvar g = 0; g < SRC_COUNT; g++) begin : g_src
    localparam int BITPOS = src_bit(g);
    logic live;
    assign live        = glob_on & en_reg[BITPOS] & pend[g];
    assign req_high[g] = live & prio_reg[BITPOS];
    assign req_low[g]  = live & ~prio_reg[BITPOS];
  end

endmodule

// File: rtl/irq_first_pick.sv
module irq_first_pick #(
  parameter  int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest index wins: scan downward so the last hit is the smallest index.
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_pkg::*;
#(
  parameter  int DEPTH = LEVEL_COUNT,
  localparam int PW    = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_e push_lvl,
  input  logic pop,
  output lvl_e active
);

  lvl_e          saved_q [DEPTH];
  logic [PW-1:0] depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= LVL_NONE;
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) saved_q[i] <= LVL_NONE;
    end else if (pop) begin
      if (depth_q != '0) begin
        active  <= saved_q[depth_q - PW'(1)];
        depth_q <= depth_q - PW'(1);
      end else begin
        active <= LVL_NONE;
      end
    end else if (push) begin
      if (depth_q < PW'(DEPTH)) begin
        saved_q[depth_q] <= active;
        depth_q          <= depth_q + PW'(1);
      end
      active <= push_lvl;
    end
  end

  // R8: strict raising bounds nesting, so a push always finds room.
  a_r8_stack_room: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> depth_q < PW'(DEPTH));

  // R8: an empty stack implies nothing is active.
  a_r8_empty_is_none: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == '0) |-> active == LVL_NONE);

endmodule

// File: rtl/irq_two_level_arbiter.sv
module irq_two_level_arbiter
  import irq_pkg::*;
#(
  parameter  int VEC_W = 16,
  localparam int IW    = $clog2(SRC_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] en_reg,
  input  logic [REG_W-1:0] prio_reg,
  input  logic [REG_W-1:0] tmr_ctl,
  input  logic [REG_W-1:0] ser_ctl,
  input  logic [REG_W-1:0] t2_ctl,
  input  logic             ret_strobe,
  output logic             take_valid,
  output logic [VEC_W-1:0] take_vector,
  output logic             take_high,
  output logic             clr_t0_ovf,
  output logic             clr_t1_ovf,
  output logic [1:0]       active_lvl
);

  logic [SRC_COUNT-1:0] req_lvl [LEVEL_COUNT];
  logic                 lvl_found [LEVEL_COUNT];
  logic [IW-1:0]        lvl_idx [LEVEL_COUNT];
  lvl_e                 cand_lvl;
  logic [IW-1:0]        cand_idx;
  logic [VEC_W-1:0]     cand_vec;
  logic                 accept;
  lvl_e                 active;

  // Index 0 holds low-level requests, index 1 high-level requests.
  irq_source_decode u_decode (
    .en_reg   (en_reg),
    .prio_reg (prio_reg),
    .tmr_ctl  (tmr_ctl),
    .ser_ctl  (ser_ctl),
    .t2_ctl   (t2_ctl),
    .req_high (req_lvl[1]),
    .req_low  (req_lvl[0])
  );

  for (genvar l = 0; l < LEVEL_COUNT; l++) begin : g_lvl
    irq_first_pick #(.N(SRC_COUNT)) u_pick (
      .req   (req_lvl[l]),
      .found (lvl_found[l]),
      .idx   (lvl_idx[l])
    );
  end

  // The high level is scanned first.
  always_comb begin
    cand_lvl = LVL_NONE;
    cand_idx = '0;
    if (lvl_found[1]) begin
      cand_lvl = LVL_HIGH;
      cand_idx = lvl_idx[1];
    end else if (lvl_found[0]) begin
      cand_lvl = LVL_LOW;
      cand_idx = lvl_idx[0];
    end
  end

  always_comb begin
    cand_vec = '0;
    for (int s = 0; s < SRC_COUNT; s++) begin
      if (cand_idx == IW'(s)) cand_vec = VEC_W'(src_vector(s));
    end
  end

  assign accept = (cand_lvl > active) && !ret_strobe;

  irq_level_stack #(.DEPTH(LEVEL_COUNT)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_lvl (cand_lvl),
    .pop      (ret_strobe),
    .active   (active)
  );

  assign active_lvl = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_valid  <= 1'b0;
      take_vector <= '0;
      take_high   <= 1'b0;
      clr_t0_ovf  <= 1'b0;
      clr_t1_ovf  <= 1'b0;
    end else begin
      take_valid <= accept;
      clr_t0_ovf <= accept && (cand_idx == IW'(0));
      clr_t1_ovf <= accept && (cand_idx == IW'(1));
      if (accept) begin
        take_vector <= cand_vec;
        take_high   <= (cand_lvl == LVL_HIGH);
      end
    end
  end

  // R1: nothing is accepted without the global enable.
  a_r1_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> $past(en_reg[GLOBAL_EN_BIT]));

  // R3: a low-level acceptance means no high request was pending.
  a_r3_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (take_valid && !take_high) |-> !$past(|req_lvl[1]));

  // R6: the timer 0 clear goes only with the timer 0 vector.
  a_r6_clear_t0: assert property (@(posedge clk) disable iff (!rst_n)
    clr_t0_ovf |-> (take_valid && take_vector == VEC_W'(16'h000B)));

  // R6: the timer 1 clear goes only with the timer 1 vector.
  a_r6_clear_t1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_t1_ovf |-> (take_valid && take_vector == VEC_W'(16'h001B)));

  // R6: at most one clear pulse per cycle.
  a_r6_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_t0_ovf, clr_t1_ovf}));

  // R7: an acceptance always raises the level strictly.
  a_r7_strict_raise: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> ($past(active_lvl) < (take_high ? 2'd2 : 2'd1)));

  // R8: the active level follows the level just taken.
  a_r8_active_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (active_lvl == (take_high ? 2'd2 : 2'd1)));

  // R10: a return cycle never accepts.
  a_r10_return_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret_strobe) |-> !take_valid);

endmodule

// File: tb/irq_two_level_arbiter_bench.sv
module irq_two_level_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  en_reg, prio_reg, tmr_ctl, ser_ctl, t2_ctl;
  logic        ret_strobe;
  logic        take_valid, take_high, clr_t0_ovf, clr_t1_ovf;
  logic [15:0] take_vector;
  logic [1:0]  active_lvl;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irq_two_level_arbiter u_irq_two_level_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_reg      (en_reg),
    .prio_reg    (prio_reg),
    .tmr_ctl     (tmr_ctl),
    .ser_ctl     (ser_ctl),
    .t2_ctl      (t2_ctl),
    .ret_strobe  (ret_strobe),
    .take_valid  (take_valid),
    .take_vector (take_vector),
    .take_high   (take_high),
    .clr_t0_ovf  (clr_t0_ovf),
    .clr_t1_ovf  (clr_t1_ovf),
    .active_lvl  (active_lvl)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One cycle later: an acceptance with the given vector and level.
  task automatic expect_take(string req, int vec, bit hi, bit c0, bit c1);
    @(negedge clk);
    chk(req, "take_valid", int'(take_valid), 1);
    chk(req, "take_vector", int'(take_vector), vec);
    chk(req, "take_high", int'(take_high), int'(hi));
    chk(req, "clr_t0_ovf", int'(clr_t0_ovf), int'(c0));
    chk(req, "clr_t1_ovf", int'(clr_t1_ovf), int'(c1));
    chk(req, "active_lvl", int'(active_lvl), hi ? 2 : 1);
    if (clr_t0_ovf) tmr_ctl[5] = 1'b0;
    if (clr_t1_ovf) tmr_ctl[7] = 1'b0;
  endtask

  task automatic expect_idle(string req, int act_exp);
    @(negedge clk);
    chk(req, "take_valid", int'(take_valid), 0);
    chk(req, "clr pulses", int'({clr_t0_ovf, clr_t1_ovf}), 0);
    chk(req, "active_lvl", int'(active_lvl), act_exp);
  endtask

  task automatic do_return(string req, int act_exp);
    ret_strobe = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0;
    chk(req, "take_valid on return", int'(take_valid), 0);
    chk(req, "active_lvl after return", int'(active_lvl), act_exp);
  endtask

  task automatic t_reset();
    chk("R7", "reset active_lvl", int'(active_lvl), 0);
    chk("R9", "reset take_valid", int'(take_valid), 0);
    chk("R6", "reset clears", int'({clr_t0_ovf, clr_t1_ovf}), 0);
  endtask

  task automatic t_global_gate();
    en_reg = 8'h02; prio_reg = 8'h00; tmr_ctl = 8'h20;
    expect_idle("R1", 0);
    expect_idle("R1", 0);
    en_reg = 8'h82;
    expect_take("R1", 16'h000B, 1'b0, 1'b1, 1'b0);
    expect_idle("R9", 1);
    do_return("R8", 0);
  endtask

  task automatic t_own_enable();
    en_reg = 8'hB8; prio_reg = 8'h00; tmr_ctl = 8'h20;
    expect_idle("R2", 0);
    t2_ctl = 8'h80;
    expect_take("R2", 16'h002B, 1'b0, 1'b0, 1'b0);
    t2_ctl = 8'h00; tmr_ctl = 8'h00;
    do_return("R2", 0);
  endtask

  task automatic t_order();
    en_reg = 8'hBA; prio_reg = 8'h00;
    tmr_ctl = 8'hA0; ser_ctl = 8'h01; t2_ctl = 8'h80;
    expect_take("R4", 16'h000B, 1'b0, 1'b1, 1'b0);
    do_return("R4", 0);
    expect_take("R4", 16'h001B, 1'b0, 1'b0, 1'b1);
    do_return("R4", 0);
    expect_take("R5", 16'h0023, 1'b0, 1'b0, 1'b0);
    chk("R6", "serial flag untouched", int'(ser_ctl), 1);
    ser_ctl = 8'h00;
    do_return("R4", 0);
    expect_take("R5", 16'h002B, 1'b0, 1'b0, 1'b0);
    t2_ctl = 8'h00;
    do_return("R4", 0);
    expect_idle("R4", 0);
  endtask

  task automatic t_high_first();
    en_reg = 8'hBA; prio_reg = 8'h20;
    tmr_ctl = 8'h20; t2_ctl = 8'h80;
    expect_take("R3", 16'h002B, 1'b1, 1'b0, 1'b0);
    expect_idle("R7", 2);
    t2_ctl = 8'h00;
    do_return("R8", 0);
    expect_take("R3", 16'h000B, 1'b0, 1'b1, 1'b0);
    do_return("R8", 0);
  endtask

  task automatic t_nesting();
    en_reg = 8'hBA; prio_reg = 8'h02;
    ser_ctl = 8'h02;
    expect_take("R5", 16'h0023, 1'b0, 1'b0, 1'b0);
    tmr_ctl = 8'h80;
    expect_idle("R7", 1);
    expect_idle("R7", 1);
    tmr_ctl = 8'hA0;
    expect_take("R7", 16'h000B, 1'b1, 1'b1, 1'b0);
    expect_idle("R7", 2);
    do_return("R8", 1);
    expect_idle("R8", 1);
    ser_ctl = 8'h00; tmr_ctl = 8'h00;
    do_return("R8", 0);
    expect_idle("R8", 0);
    do_return("R8", 0);
    expect_idle("R8", 0);
  endtask

  task automatic t_return_same_cycle();
    en_reg = 8'h88; prio_reg = 8'h00; tmr_ctl = 8'h80;
    ret_strobe = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0;
    chk("R10", "take_valid with return", int'(take_valid), 0);
    chk("R10", "active_lvl with return", int'(active_lvl), 0);
    expect_take("R10", 16'h001B, 1'b0, 1'b0, 1'b1);
    do_return("R10", 0);
  endtask

  initial begin
    rst_n = 1'b0; ret_strobe = 1'b0;
    en_reg = '0; prio_reg = '0; tmr_ctl = '0; ser_ctl = '0; t2_ctl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_global_gate();
    t_own_enable();
    t_order();
    t_high_first();
    t_nesting();
    t_return_same_cycle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule